// File: doc/BRIEF.md
# Counter-Addressed Microprogram Sequencer

The block steps through a small control store that a loadable counter addresses. Microwords sit in the store in execution order, so on each clock the counter normally moves to the next address. The counter reaches a new microroutine only through one bit of the microword, the chain bit. When the word being executed has that bit set, the counter takes the external start address on the next clock and continues from there. The store holds no next-address field.

The control store is a constant table that is computed inside the block. Surrounding logic reads the control field and the chain bit directly from the current word, and it sees the address that is executing now. It selects the next routine by placing a start address on the bus before the final word of the current routine ends.

Top module: `useq_top`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises, addr_o is 0. The outputs show word 0 of the store.
- R2: Pulling rst_ni low forces addr_o to 0 at once. This holds even when the current word has its chain bit set and a start address is present.
- R3: On a clock edge where chain_o is 0, addr_o advances by exactly one.
- R4: On a clock edge where chain_o is 1, addr_o takes the value that start_addr_i holds at that edge.
- R5: start_addr_i has no effect on any clock edge where chain_o is 0. The address still advances by one.
- R6: When chain_o is 0 at the highest address (2^ADDR_W-1), the next address is 0.
- R7: The default store has 16 words. The control field at address a is (7*a+3) mod 64. chain_o is 1 only at address 4, the last word of the five-word routine 0..4, and at address 7, the last word of the three-word routine 5..7. Words 8..15 run straight through and wrap into address 0.
- R8: ctrl_o and chain_o always show the word at the current addr_o, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | ADDR_W | Start address taken when the chain bit is set |
| ctrl_o | output | CTRL_W | Control field of the current word |
| chain_o | output | 1 | Chain bit of the current word |
| addr_o | output | ADDR_W | Address now executing |

## Verification
The only state is the counter, and every output is a function of it. A wrong count therefore shows up on addr_o, ctrl_o and chain_o in the same cycle. A chain taken on the wrong edge, or a wrong start address, shows on the first clock after the fault. The bench follows the whole address order through both routines, the wrap and a reset taken in the middle of a routine. At every step it compares all three outputs with values it computes itself.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_CTRL_W = 6;

  // control pattern of the default image
  function automatic logic [31:0] ctrl_pattern(input int unsigned a);
    return 32'(a * 7 + 3);
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int unsigned ADDR_W = useq_pkg::DEF_ADDR_W,
  parameter int unsigned CTRL_W = useq_pkg::DEF_CTRL_W,
  parameter int unsigned END_A  = 4,
  parameter int unsigned END_B  = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              chain_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned WORD_W = CTRL_W + 1;

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [31:0] CV = useq_pkg::ctrl_pattern(g);
    localparam logic        LB = (g == END_A) || (g == END_B);
    assign rom[g] = {LB, CV[CTRL_W-1:0]};
  end

  always_comb begin
    {chain_o, ctrl_o} = rom[addr_i];
  end
endmodule

// File: rtl/useq_counter.sv
module useq_counter #(
  parameter int unsigned ADDR_W = useq_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic [ADDR_W-1:0] cnt_o
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= start_i;
    else             cnt_q <= cnt_q + ADDR_W'(1);
  end

  assign cnt_o = cnt_q;

  // R1 R2
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_chk: assert (cnt_q == '0);
    end
  end

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(start_i));

  // R3 R5
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q == $past(cnt_q) + ADDR_W'(1));

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == TOP) |=> cnt_q == '0);
endmodule

// File: rtl/useq_top.sv
module useq_top #(
  parameter int unsigned ADDR_W = useq_pkg::DEF_ADDR_W,
  parameter int unsigned CTRL_W = useq_pkg::DEF_CTRL_W,
  parameter int unsigned END_A  = 4,
  parameter int unsigned END_B  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              chain_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr;
  logic              chain;

  useq_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (chain),
    .start_i(start_addr_i),
    .cnt_o  (addr)
  );

  useq_rom #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .END_A(END_A), .END_B(END_B)
  ) u_rom (
    .addr_i (addr),
    .ctrl_o (ctrl_o),
    .chain_o(chain)
  );

  assign chain_o = chain;
  assign addr_o  = addr;
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int AW = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] start = '0;
  logic [CW-1:0] ctrl;
  logic          chain;
  logic [AW-1:0] addr;

  int n_chk = 0;
  int n_bad = 0;

  useq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_addr_i(start),
    .ctrl_o(ctrl), .chain_o(chain), .addr_o(addr)
  );

  always #5 clk = ~clk;

  task automatic expect_at(input string req, input int a);
    logic [CW-1:0] ec;
    logic          el;
    ec = CW'((a * 7 + 3) % 64);
    el = (a == 4) || (a == 7);
    n_chk++;
    if (addr !== AW'(a) || ctrl !== ec || chain !== el) begin
      n_bad++;
      $display("FAIL %s: addr=%0d ctrl=%0d chain=%0b, expected addr=%0d ctrl=%0d chain=%0b",
               req, addr, ctrl, chain, a, ec, el);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    expect_at("R1", 0);
    step();
    expect_at("R1", 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    expect_at("R1 R3", 1);
  endtask

  // routine 0..4 chains to 5..7, start changes while not chaining are ignored
  task automatic t_chain();
    start = 4'd5;
    for (int a = 2; a <= 4; a++) begin
      step();
      expect_at("R3 R7 R8", a);
    end
    step();
    expect_at("R4", 5);
    @(negedge clk);
    start = 4'd12;
    step();
    expect_at("R5", 6);
    @(negedge clk);
    start = 4'd9;
    step();
    expect_at("R5", 7);
    @(negedge clk);
    start = 4'd8;
    step();
    expect_at("R4", 8);
  endtask

  task automatic t_wrap();
    start = 4'd3;
    for (int a = 9; a <= 15; a++) begin
      step();
      expect_at("R3 R7", a);
    end
    step();
    expect_at("R6", 0);
    step();
    expect_at("R6", 1);
  endtask

  task automatic t_mid_reset();
    start = 4'd9;
    while (addr != 4'd4) step();
    expect_at("R7", 4);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_at("R2", 0);
    step();
    expect_at("R2", 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_at("R2", 0);
    step();
    expect_at("R2 R3", 1);
  endtask

  // routine 5..7 chains back to a start address of 0
  task automatic t_chain_back();
    start = 4'd5;
    while (addr != 4'd4) step();
    step();
    expect_at("R4", 5);
    start = 4'd0;
    step();
    step();
    expect_at("R7", 7);
    step();
    expect_at("R4", 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_chain();
        t_wrap();
        t_mid_reset();
        t_chain_back();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule